// File: doc/BRIEF.md
# JK-Fed Parallel-Load Shift Register

This block is a small register, four bits wide by default, that can either take a whole word from a parallel bus or move its contents one place toward the most significant bit on each rising clock edge. Stage 0 is not fed by a single serial data bit. It is fed by a pair of serial controls, `j_in` and an active-low `k_n_in`. On a shift, this pair can clear, set, invert or keep the bit already in stage 0, while the upper stages take the bits below them.

An active-low master reset clears the register immediately, with no clock needed. The release of that reset passes through a short synchronizer, so the register leaves the cleared state on a known clock edge. Both the word output and the inverted copy of the top bit come straight from flip-flops. No input reaches an output without first passing through a clock edge. The block is used wherever a small word has to be loaded, shifted out, or built up bit by bit under a set/clear/toggle/keep rule.

Top module: `jk_shift_reg`

## Requirements
- R1: While `mrst_n` is 0, `q` is 0000 and `q_msb_n` is 1. The clear takes effect as soon as `mrst_n` falls, with no clock edge, and it persists through any rising edges while `mrst_n` stays low.
- R2: After `mrst_n` rises, the first two rising clock edges leave the register cleared. The third rising edge is the first one that loads or shifts.
- R3: On a rising edge with `load_n` = 0, `q[i]` takes `par_d[i]` for every bit i, so `par_d[0]` goes to `q[0]`.
- R4: On a rising edge with `load_n` = 1, `q[i]` takes the old `q[i-1]` for i = 1 to 3.
- R5: On a rising edge with `load_n` = 1, the new `q[0]` follows {`j_in`,`k_n_in`}. 00 gives 0, 11 gives 1, 10 gives the inverse of the old `q[0]`, and 01 keeps the old `q[0]`. "Old" means the value stored before the edge.
- R6: `q_msb_n` is always the complement of `q[3]`.
- R7: Changes on `load_n`, `j_in`, `k_n_in` and `par_d` between rising edges, including at falling edges, leave `q` and `q_msb_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| mrst_n | input | 1 | Master reset, active low, asynchronous assertion |
| j_in | input | 1 | Serial control J for stage 0 |
| k_n_in | input | 1 | Serial control K, active low, for stage 0 |
| par_d | input | 4 | Parallel word, bit i loads into q[i] |
| load_n | input | 1 | 0 selects parallel load, 1 selects shift |
| q | output | 4 | Registered word |
| q_msb_n | output | 1 | Registered complement of q[3] |

## Verification
The clocked assertions assume that `load_n`, `j_in`, `k_n_in` and `par_d` are stable around each rising edge. They also stay silent while the synchronized reset is low. A reset that lands between two edges therefore never produces a false mismatch against the values sampled before it. The stimulus changes the data inputs only at falling edges and drops `mrst_n` partway through a low clock phase. It then holds `mrst_n` low across at least one rising edge, so every edge the assertions judge sees settled inputs and a steady reset level.

// File: rtl/jksr_pkg.sv
`timescale 1ns/1ps
package jksr_pkg;

    localparam int unsigned DEF_WIDTH       = 4;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Serial control pair driving stage 0
    typedef struct packed {
        logic j;
        logic k_n;
    } jk_pair_t;

    // Action selected by {j, k_n}
    typedef enum logic [1:0] {
        JK_CLEAR = 2'b00,
        JK_KEEP  = 2'b01,
        JK_FLIP  = 2'b10,
        JK_SET   = 2'b11
    } jk_action_t;

    // Operation performed on a rising edge
    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_SHIFT = 1'b1
    } edge_op_t;

    function automatic jk_action_t jk_decode(jk_pair_t p);
        return jk_action_t'({p.j, p.k_n});
    endfunction

    function automatic logic jk_apply(jk_action_t act, logic cur);
        logic nxt;
        case (act)
            JK_CLEAR: nxt = 1'b0;
            JK_SET:   nxt = 1'b1;
            JK_FLIP:  nxt = ~cur;
            default:  nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/jksr_rst_sync.sv
`timescale 1ns/1ps
module jksr_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_out
);

    generate
        if (STAGES <= 1) begin : g_single
            logic flop;
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) flop <= 1'b0;
                else         flop <= 1'b1;
            end
            assign rst_n_out = flop;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain <= '0;
                else         chain <= {chain[STAGES-2:0], 1'b1};
            end
            assign rst_n_out = chain[STAGES-1];
        end
    endgenerate

    AST_SYNC_FOLLOWS_ASSERT: assert property (@(posedge clk)
        !arst_n |-> !rst_n_out);                                   // R1

    AST_SYNC_RELEASE_LATE: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_n_out) |-> $past(arst_n));                      // R2

endmodule

// File: rtl/jksr_stage0.sv
`timescale 1ns/1ps
module jksr_stage0
    import jksr_pkg::*;
(
    input  jk_pair_t serial,
    input  logic     q_old,
    output logic     q_new
);

    jk_action_t act;

    always_comb begin
        act   = jk_decode(serial);
        q_new = jk_apply(act, q_old);
    end

endmodule

// File: rtl/jksr_shift_core.sv
`timescale 1ns/1ps
module jksr_shift_core
    import jksr_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  edge_op_t         op,
    input  jk_pair_t         serial,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] q,
    output logic             q_msb_n
);

    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] q_r;
    logic             q_inv_r;
    logic [WIDTH-1:0] shift_vec;
    logic [WIDTH-1:0] q_nxt;
    logic             stage0_nxt;

    jksr_stage0 u_stage0 (
        .serial (serial),
        .q_old  (q_r[0]),
        .q_new  (stage0_nxt)
    );

    assign shift_vec[0] = stage0_nxt;

    generate
        for (genvar i = 1; i < WIDTH; i++) begin : g_upper
            assign shift_vec[i] = q_r[i-1];
        end
    endgenerate

    always_comb begin
        case (op)
            OP_LOAD: q_nxt = par_d;
            default: q_nxt = shift_vec;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r     <= '0;
            q_inv_r <= 1'b1;
        end else begin
            q_r     <= q_nxt;
            q_inv_r <= ~q_nxt[MSB];
        end
    end

    assign q       = q_r;
    assign q_msb_n = q_inv_r;

    AST_CLEARED_IN_RESET: assert property (@(negedge clk)
        !rst_n |-> (q_r == '0 && q_inv_r));                        // R1

    AST_LOAD_COPIES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (q_r == $past(par_d)));                // R3

    AST_SHIFT_MOVES_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> (q_r[MSB:1] == $past(q_r[MSB-1:0]))); // R4

    AST_JK_FLIP_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT && serial.j && !serial.k_n) |=> (q_r[0] != $past(q_r[0]))); // R5

    AST_JK_KEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT && !serial.j && serial.k_n) |=> (q_r[0] == $past(q_r[0]))); // R5

    AST_MSB_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        q_inv_r != q_r[MSB]);                                      // R6

endmodule

// File: rtl/jk_shift_reg.sv
`timescale 1ns/1ps
module jk_shift_reg
    import jksr_pkg::*;
#(
    parameter int unsigned WIDTH       = DEF_WIDTH,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             j_in,
    input  logic             k_n_in,
    input  logic [WIDTH-1:0] par_d,
    input  logic             load_n,
    output logic [WIDTH-1:0] q,
    output logic             q_msb_n
);

    logic     rst_n_s;
    jk_pair_t serial;
    edge_op_t op;

    always_comb begin
        serial.j   = j_in;
        serial.k_n = k_n_in;
        op         = load_n ? OP_SHIFT : OP_LOAD;
    end

    jksr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk       (clk),
        .arst_n    (mrst_n),
        .rst_n_out (rst_n_s)
    );

    jksr_shift_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .rst_n   (rst_n_s),
        .op      (op),
        .serial  (serial),
        .par_d   (par_d),
        .q       (q),
        .q_msb_n (q_msb_n)
    );

endmodule

// File: tb/tb_jk_shift_reg.sv
`timescale 1ns/1ps
module tb_jk_shift_reg;

    logic       clk = 1'b0;
    logic       mrst_n;
    logic       j_in;
    logic       k_n_in;
    logic [3:0] par_d;
    logic       load_n;
    logic [3:0] q;
    logic       q_msb_n;

    int checks   = 0;
    int failures = 0;
    logic [3:0] exp_q;

    always #10 clk = ~clk;

    jk_shift_reg dut (
        .clk     (clk),
        .mrst_n  (mrst_n),
        .j_in    (j_in),
        .k_n_in  (k_n_in),
        .par_d   (par_d),
        .load_n  (load_n),
        .q       (q),
        .q_msb_n (q_msb_n)
    );

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] want);
        checks++;
        if (got !== want) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, got, want, $time);
        end
    endtask

    task automatic chk_all(input string req, input logic [3:0] want);
        chk(req, q, want);
        chk("R6", {3'b000, q_msb_n}, {3'b000, ~want[3]});
    endtask

    function automatic logic [3:0] ref_next(logic [3:0] cur, logic ld_n, logic jj,
                                            logic kk, logic [3:0] d);
        logic b0;
        if (!ld_n) return d;
        case ({jj, kk})
            2'b00:   b0 = 1'b0;
            2'b11:   b0 = 1'b1;
            2'b10:   b0 = ~cur[0];
            default: b0 = cur[0];
        endcase
        return {cur[2:0], b0};
    endfunction

    // Drive at the falling edge, sample 5 ns after the next rising edge
    task automatic step(input logic ld_n, input logic jj, input logic kk,
                        input logic [3:0] d, input string req);
        @(negedge clk);
        load_n = ld_n; j_in = jj; k_n_in = kk; par_d = d;
        @(posedge clk);
        #5;
        exp_q = ref_next(exp_q, ld_n, jj, kk, d);
        chk_all(req, exp_q);
    endtask

    task automatic release_and_check();
        @(negedge clk);
        load_n = 1'b0; par_d = 4'b1111; mrst_n = 1'b1;
        for (int e = 0; e < 2; e++) begin
            @(posedge clk); #5;
            chk_all("R2", 4'b0000);
        end
        @(posedge clk); #5;
        exp_q = 4'b1111;
        chk_all("R2", exp_q);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        mrst_n = 1'b0; j_in = 1'b0; k_n_in = 1'b0; par_d = 4'b0101; load_n = 1'b0;
        exp_q = 4'b0000;
        #15;
        chk_all("R1", 4'b0000);            // reset state
        @(posedge clk); #5;
        chk_all("R1", 4'b0000);            // held through a rising edge

        release_and_check();               // R2 then a load

        // R3: every parallel word
        for (int v = 0; v < 16; v++) step(1'b0, 1'b0, 1'b0, 4'(v), "R3");

        // R4/R5: each start word with each serial pair, arithmetic expectation
        for (int v = 0; v < 16; v++) begin
            for (int a = 0; a < 4; a++) begin
                logic [3:0] sv;
                logic       b0;
                sv = 4'(v);
                step(1'b0, 1'b0, 1'b0, sv, "R3");
                @(negedge clk);
                load_n = 1'b1; j_in = a[1]; k_n_in = a[0];
                @(posedge clk); #5;
                b0 = (a == 0) ? 1'b0 : (a == 3) ? 1'b1 : (a == 2) ? ~sv[0] : sv[0];
                chk("R4", {1'b0, q[3:1]}, {1'b0, sv[2:0]});
                chk("R5", {3'b000, q[0]}, {3'b000, b0});
                chk("R6", {3'b000, q_msb_n}, {3'b000, ~sv[2]});
                exp_q = {sv[2:0], b0};
            end
        end

        // Load a pattern and shift it out with zeros
        step(1'b0, 1'b0, 1'b0, 4'b1010, "R3");
        for (int s = 0; s < 4; s++) step(1'b1, 1'b0, 1'b0, 4'b1111, "R4");
        chk_all("R4", 4'b0000);

        // Shift in ones
        for (int s = 0; s < 4; s++) step(1'b1, 1'b1, 1'b1, 4'b0000, "R5");
        chk_all("R5", 4'b1111);

        // Toggle across successive edges from zero
        step(1'b0, 1'b0, 1'b0, 4'b0000, "R3");
        for (int s = 0; s < 4; s++) step(1'b1, 1'b1, 1'b0, 4'b0000, "R5");
        chk_all("R5", 4'b1010);

        // Keep stage 0 while the upper bits shift
        step(1'b0, 1'b0, 1'b0, 4'b0001, "R3");
        for (int s = 0; s < 3; s++) step(1'b1, 1'b0, 1'b1, 4'b0000, "R5");
        chk_all("R5", 4'b1111);

        // R7: input changes between rising edges do nothing
        step(1'b0, 1'b0, 1'b0, 4'b0110, "R3");
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            #1;
            chk_all("R7", exp_q);
            load_n = s[0]; j_in = s[1]; k_n_in = ~s[0]; par_d = ~exp_q;
            #4;
            chk_all("R7", exp_q);
            load_n = 1'b1; j_in = 1'b0; k_n_in = 1'b1; par_d = 4'b0000;
            @(posedge clk); #5;
            exp_q = ref_next(exp_q, 1'b1, 1'b0, 1'b1, 4'b0000);
            chk_all("R7", exp_q);
        end

        // Reset in the middle of a shift run
        step(1'b0, 1'b0, 1'b0, 4'b1011, "R3");
        step(1'b1, 1'b1, 1'b1, 4'b0000, "R4");
        @(negedge clk);
        #3;
        mrst_n = 1'b0;
        #2;
        exp_q = 4'b0000;
        chk_all("R1", exp_q);              // cleared without a clock edge
        @(posedge clk); #5;
        chk_all("R1", exp_q);
        release_and_check();
        step(1'b1, 1'b1, 1'b0, 4'b0000, "R5");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule